// File: doc/BRIEF.md
# Home-Node Exclusive-Ownership Handler

This block is the home-node controller for one slice of a directory-based cache-coherence protocol. Every cache line in the slice has a small request queue. Requests are accepted into the queue selected by their address. Only the request at the head of each queue is considered, so two requests to the same line never overlap. A scan pointer visits the line addresses in turn. For the visited line the block presents the address on `look_addr_o`. The surrounding logic answers in the same cycle with the directory entry (state and owner vector) and with the result of probing the local cache and victim buffer.

The block acts when the head request asks for exclusive ownership, the directory says Shared, and the probe reports that memory holds the data. Every sharer except the requester then gets one invalidate, at one per cycle. The requester gets a grant that tells it how many invalidation acknowledgements to expect. In the same cycle as the grant, the block writes the new directory entry and retires the request. The directory storage, the network and the caches stay outside the block.

Top module: `hn_home_excl`

## Requirements
- R1: While reset is held and in the first cycle after it, `inv_valid_o`, `grant_valid_o`, `dir_wr_o` and `retire_valid_o` are low, and `req_ready_o` is high for every address.
- R2: Each line address has a FIFO of QDEPTH entries (16 by default, 64 requests over the 4 lines). `req_ready_o` is low while the queue for `req_addr_i` is full. Requests to one address are served strictly in arrival order, one at a time.
- R3: A head request is served only when three things hold at once: its command is exclusive-ownership (`req_cmd_i`=1; 0 is a read), `dir_state_i` is Shared (encoding 1), and `probe_mem_i` is high. Otherwise the request stays at the head, produces no message, and does not block other addresses.
- R4: The invalidation targets are the owner vector with the requester's bit cleared. One invalidate goes out per target, one per cycle, in ascending processor number.
- R5: The grant goes to the requester. `grant_count_o` equals the number of targets. The grant appears in the cycle after the last invalidate, or in the cycle after acceptance when there are no targets.
- R6: With the grant, the block writes the directory entry of the same address. For a requester other than HOME_ID, the new state is Exclusive (encoding 2) and the owner vector holds only the requester's bit.
- R7: When the requester is HOME_ID, the written state is Stale (encoding 3) and the owner vector holds only the home node's bit.
- R8: In the grant cycle, `retire_valid_o` pulses with the address. The head entry of that queue is popped and the line's tracking state returns to idle. The next request of that address is then examined against the updated directory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request offered this cycle |
| req_addr_i | input | AW | Line address of the request |
| req_pid_i | input | PW | Requesting processor number |
| req_cmd_i | input | 1 | 1 = exclusive ownership, 0 = read |
| req_ready_o | output | 1 | Queue for `req_addr_i` has room |
| look_addr_o | output | AW | Address whose directory entry and probe result are needed |
| dir_state_i | input | 2 | Directory state of `look_addr_o` (0 Invalid, 1 Shared, 2 Exclusive, 3 Stale) |
| dir_owners_i | input | NUM_PROC | Owner/sharer vector of `look_addr_o`, one bit per processor |
| probe_mem_i | input | 1 | Probe of local cache and victim buffer: memory holds the data |
| inv_valid_o | output | 1 | Invalidate message strobe |
| inv_dest_o | output | PW | Invalidate destination |
| grant_valid_o | output | 1 | Exclusive-grant message strobe |
| grant_dest_o | output | PW | Grant destination (requester) |
| grant_count_o | output | CW | Acknowledgements the requester must wait for |
| dir_wr_o | output | 1 | Directory write strobe |
| dir_wr_addr_o | output | AW | Directory write address |
| dir_wr_state_o | output | 2 | New directory state |
| dir_wr_owners_o | output | NUM_PROC | New owner vector |
| retire_valid_o | output | 1 | Request retired strobe |
| retire_addr_o | output | AW | Address of the retired request |

## Verification
The assertions assume that the directory and probe inputs answer in the same cycle for whatever `look_addr_o` shows. They also assume that the directory entry of a line changes only through `dir_wr_o` while that line has a transaction in flight. The bench meets both conditions with a directory model that it reads combinationally and updates on each write strobe. It changes an entry from its own stimulus only while no request for that line is being served. Blocked requests are set up and then released one line at a time, so every expected message sequence is known before the design can produce it.

// File: rtl/hn_pkg.sv
// Package: shared encodings of the home-node exclusive-request handler.
// Assumes: directory state and command encodings are fixed by the
// surrounding directory storage and request network.
package hn_pkg;

    typedef enum logic [1:0] {
        DIR_INVALID = 2'd0,
        DIR_SHARED  = 2'd1,
        DIR_EXCL    = 2'd2,
        DIR_STALE   = 2'd3
    } dir_state_e;

    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_RDMOD = 1'b1
    } cmd_e;

    typedef enum logic [1:0] {
        CTL_SCAN  = 2'd0,
        CTL_INVAL = 2'd1,
        CTL_GRANT = 2'd2
    } ctl_state_e;

    typedef enum logic {
        TRK_NONE   = 1'b0,
        TRK_ACTIVE = 1'b1
    } trk_state_e;

endpackage

// File: rtl/hn_req_fifo.sv
// Module: per-address request FIFO.
// Holds the queued requests of one line address in arrival order and
// exposes only the head entry.
// Assumes: push is never asserted while full and pop never while empty
// (the top gates both).
module hn_req_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem_q [DEPTH];
    logic [PTRW-1:0] rd_q, wr_q;
    logic [CNTW-1:0] cnt_q;

    // Next pointer value with wrap at DEPTH-1.
    function automatic logic [PTRW-1:0] ptr_inc(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + PTRW'(1);
    endfunction

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_q] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= ptr_inc(wr_q);
            if (pop)  rd_q <= ptr_inc(rd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNTW'(1);
                2'b01:   cnt_q <= cnt_q - CNTW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Head and status outputs.
    always_comb begin
        dout  = mem_q[rd_q];
        empty = (cnt_q == '0);
        full  = (cnt_q == CNTW'(DEPTH));
    end

    // R2: the top never pushes into a full queue.
    a_r2_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R8: a retire only pops a queue that holds a request.
    a_r8_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/hn_target_sel.sv
// Module: target-vector helper.
// Gives the lowest set bit of a vector, the vector with that bit
// cleared, and the population count.
// Assumes: purely combinational; N >= 2.
module hn_target_sel #(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] low_idx,
    output logic [N-1:0]  rest,
    output logic [CW-1:0] pop
);
    // Priority encoder: the lowest set bit wins.
    always_comb begin
        low_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) low_idx = IW'(i);
        end
    end

    // Clears the lowest set bit.
    always_comb begin
        rest = vec & (vec - N'(1));
        any  = |vec;
    end

    // Population count of the vector.
    always_comb begin
        pop = '0;
        for (int i = 0; i < N; i++) begin
            pop = pop + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/hn_home_excl.sv
// Module: home-node exclusive-ownership handler (top).
// Queues requests per line address and scans the heads. For an
// exclusive request on a Shared line whose data is in memory, it sends
// invalidates to the other sharers, then a counted grant together with
// a directory write, and retires the request.
// Assumes: dir_state_i, dir_owners_i and probe_mem_i describe
// look_addr_o in the same cycle; NUM_ADDR >= 2, NUM_PROC >= 2.
module hn_home_excl #(
    parameter int NUM_PROC = 8,
    parameter int NUM_ADDR = 4,
    parameter int QDEPTH   = 16,
    parameter int HOME_ID  = 0,
    parameter int AW       = $clog2(NUM_ADDR),
    parameter int PW       = $clog2(NUM_PROC),
    parameter int CW       = $clog2(NUM_PROC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic [AW-1:0]       req_addr_i,
    input  logic [PW-1:0]       req_pid_i,
    input  logic                req_cmd_i,
    output logic                req_ready_o,
    output logic [AW-1:0]       look_addr_o,
    input  logic [1:0]          dir_state_i,
    input  logic [NUM_PROC-1:0] dir_owners_i,
    input  logic                probe_mem_i,
    output logic                inv_valid_o,
    output logic [PW-1:0]       inv_dest_o,
    output logic                grant_valid_o,
    output logic [PW-1:0]       grant_dest_o,
    output logic [CW-1:0]       grant_count_o,
    output logic                dir_wr_o,
    output logic [AW-1:0]       dir_wr_addr_o,
    output logic [1:0]          dir_wr_state_o,
    output logic [NUM_PROC-1:0] dir_wr_owners_o,
    output logic                retire_valid_o,
    output logic [AW-1:0]       retire_addr_o
);
    import hn_pkg::*;

    localparam int EW = PW + 1;  // queue entry: {cmd, pid}

    // Queue signals, one set per line address.
    logic [NUM_ADDR-1:0] push_v, pop_v, empty_v, full_v;
    logic [EW-1:0]       head_v [NUM_ADDR];

    // Control state.
    ctl_state_e          st_q;
    logic [AW-1:0]       scan_q, cur_addr_q;
    logic [PW-1:0]       cur_pid_q;
    logic [NUM_PROC-1:0] remain_q;
    logic [CW-1:0]       count_q;
    trk_state_e          trk_q [NUM_ADDR];

    // Head of the scanned queue.
    logic                head_valid, head_cmd, accept;
    logic [PW-1:0]       head_pid;
    logic [NUM_PROC-1:0] req_bit, targets_new;

    // Helper outputs.
    logic                new_any, rem_any;
    logic [PW-1:0]       new_low_unused, rem_low;
    logic [NUM_PROC-1:0] new_rest_unused, rem_rest;
    logic [CW-1:0]       new_pop, rem_pop_unused;

    // One request FIFO per line address.
    for (genvar a = 0; a < NUM_ADDR; a++) begin : g_q
        hn_req_fifo #(.DEPTH(QDEPTH), .W(EW)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[a]),
            .din   ({req_cmd_i, req_pid_i}),
            .pop   (pop_v[a]),
            .dout  (head_v[a]),
            .empty (empty_v[a]),
            .full  (full_v[a])
        );
        // Steers an accepted request into its address queue.
        always_comb push_v[a] = req_valid_i && req_ready_o && (req_addr_i == AW'(a));
        // Pops the queue whose transaction is retiring.
        always_comb pop_v[a]  = (st_q == CTL_GRANT) && (cur_addr_q == AW'(a));
    end

    // Back-pressure for the addressed queue.
    always_comb req_ready_o = !full_v[req_addr_i];

    // Address presented to the directory and probe logic.
    always_comb look_addr_o = (st_q == CTL_SCAN) ? scan_q : cur_addr_q;

    // Decodes the scanned head and tests the three preconditions.
    always_comb begin
        head_valid  = !empty_v[scan_q];
        head_cmd    = head_v[scan_q][EW-1];
        head_pid    = head_v[scan_q][PW-1:0];
        req_bit     = NUM_PROC'(1) << head_pid;
        targets_new = dir_owners_i & ~req_bit;
        accept      = (st_q == CTL_SCAN) && head_valid
                      && (head_cmd == CMD_RDMOD)
                      && (dir_state_i == DIR_SHARED)
                      && probe_mem_i;
    end

    // Counts the targets of a newly accepted request.
    hn_target_sel #(.N(NUM_PROC), .IW(PW), .CW(CW)) u_new_sel (
        .vec     (targets_new),
        .any     (new_any),
        .low_idx (new_low_unused),
        .rest    (new_rest_unused),
        .pop     (new_pop)
    );

    // Picks the next invalidate destination from the remaining targets.
    hn_target_sel #(.N(NUM_PROC), .IW(PW), .CW(CW)) u_rem_sel (
        .vec     (remain_q),
        .any     (rem_any),
        .low_idx (rem_low),
        .rest    (rem_rest),
        .pop     (rem_pop_unused)
    );

    // Next scan address with wrap.
    function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
        return (a == AW'(NUM_ADDR - 1)) ? '0 : a + AW'(1);
    endfunction

    // Transaction sequencer: scan, invalidate, grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= CTL_SCAN;
            scan_q     <= '0;
            cur_addr_q <= '0;
            cur_pid_q  <= '0;
            remain_q   <= '0;
            count_q    <= '0;
        end else begin
            case (st_q)
                CTL_SCAN: begin
                    if (accept) begin
                        cur_addr_q <= scan_q;
                        cur_pid_q  <= head_pid;
                        remain_q   <= targets_new;
                        count_q    <= new_pop;
                        st_q       <= new_any ? CTL_INVAL : CTL_GRANT;
                    end else begin
                        scan_q <= addr_inc(scan_q);
                    end
                end
                CTL_INVAL: begin
                    remain_q <= rem_rest;
                    if (rem_rest == '0) st_q <= CTL_GRANT;
                end
                default: begin
                    st_q   <= CTL_SCAN;
                    scan_q <= addr_inc(cur_addr_q);
                end
            endcase
        end
    end

    // Per-address tracking entry: active while its head is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NUM_ADDR; a++) trk_q[a] <= TRK_NONE;
        end else begin
            if (accept)             trk_q[scan_q]     <= TRK_ACTIVE;
            if (st_q == CTL_GRANT)  trk_q[cur_addr_q] <= TRK_NONE;
        end
    end

    // Message, directory-write and retire outputs.
    always_comb begin
        inv_valid_o     = (st_q == CTL_INVAL) && rem_any;
        inv_dest_o      = rem_low;
        grant_valid_o   = (st_q == CTL_GRANT);
        grant_dest_o    = cur_pid_q;
        grant_count_o   = count_q;
        dir_wr_o        = (st_q == CTL_GRANT);
        dir_wr_addr_o   = cur_addr_q;
        dir_wr_owners_o = NUM_PROC'(1) << cur_pid_q;
        dir_wr_state_o  = (cur_pid_q == PW'(HOME_ID)) ? DIR_STALE : DIR_EXCL;
        retire_valid_o  = (st_q == CTL_GRANT);
        retire_addr_o   = cur_addr_q;
    end

    // Checker counter: invalidates sent for the current transaction.
    logic [CW-1:0] inv_sent_q;
    always_ff @(posedge clk) begin
        if (!rst_n)           inv_sent_q <= '0;
        else if (accept)      inv_sent_q <= '0;
        else if (inv_valid_o) inv_sent_q <= inv_sent_q + CW'(1);
    end

    // R3: a scan that sees a non-Shared line does not start a transaction.
    a_r3_needs_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CTL_SCAN && dir_state_i != DIR_SHARED) |=> (st_q == CTL_SCAN));

    // R4: the requester is never invalidated.
    a_r4_inv_not_requester: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid_o |-> (inv_dest_o != grant_dest_o));

    // R4: invalidates and grant never share a cycle.
    a_r4_inv_grant_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_valid_o && grant_valid_o));

    // R5: the grant count equals the invalidates actually sent.
    a_r5_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> (grant_count_o == inv_sent_q));

    // R5: the grant follows the last invalidate directly.
    a_r5_grant_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid_o && $countones(remain_q) == 1) |=> grant_valid_o);

    // R6: an Exclusive write names exactly the granted processor.
    a_r6_excl_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr_o && dir_wr_state_o == DIR_EXCL) |->
            ($onehot0(dir_wr_owners_o) && grant_dest_o != PW'(HOME_ID)));

    // R7: a Stale write only happens for the home node.
    a_r7_stale_only_home: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr_o && dir_wr_state_o == DIR_STALE) |-> (grant_dest_o == PW'(HOME_ID)));

    // R8: a line is never accepted twice while its entry is active.
    a_r8_trk_idle_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (trk_q[scan_q] == TRK_NONE));

endmodule

// File: tb/hn_home_excl_tb_top.sv
// Bench: scoreboard. Tasks push expected messages into a queue and a
// negedge monitor pops and compares them against the design's strobes.
// A combinational directory model answers look_addr_o.
module hn_home_excl_tb_top;
    localparam int NUM_PROC = 8;
    localparam int NUM_ADDR = 4;
    localparam int QDEPTH   = 16;
    localparam int HOME_ID  = 0;
    localparam int AW       = $clog2(NUM_ADDR);
    localparam int PW       = $clog2(NUM_PROC);
    localparam int CW       = $clog2(NUM_PROC + 1);
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid_i = 1'b0;
    logic [AW-1:0]       req_addr_i = '0;
    logic [PW-1:0]       req_pid_i = '0;
    logic                req_cmd_i = 1'b0;
    logic                req_ready_o;
    logic [AW-1:0]       look_addr_o;
    logic [1:0]          dir_state_i;
    logic [NUM_PROC-1:0] dir_owners_i;
    logic                probe_mem_i;
    logic                inv_valid_o;
    logic [PW-1:0]       inv_dest_o;
    logic                grant_valid_o;
    logic [PW-1:0]       grant_dest_o;
    logic [CW-1:0]       grant_count_o;
    logic                dir_wr_o;
    logic [AW-1:0]       dir_wr_addr_o;
    logic [1:0]          dir_wr_state_o;
    logic [NUM_PROC-1:0] dir_wr_owners_o;
    logic                retire_valid_o;
    logic [AW-1:0]       retire_addr_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hn_home_excl #(.NUM_PROC(NUM_PROC), .NUM_ADDR(NUM_ADDR), .QDEPTH(QDEPTH),
                   .HOME_ID(HOME_ID)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
        .req_pid_i(req_pid_i), .req_cmd_i(req_cmd_i), .req_ready_o(req_ready_o),
        .look_addr_o(look_addr_o), .dir_state_i(dir_state_i),
        .dir_owners_i(dir_owners_i), .probe_mem_i(probe_mem_i),
        .inv_valid_o(inv_valid_o), .inv_dest_o(inv_dest_o),
        .grant_valid_o(grant_valid_o), .grant_dest_o(grant_dest_o),
        .grant_count_o(grant_count_o), .dir_wr_o(dir_wr_o),
        .dir_wr_addr_o(dir_wr_addr_o), .dir_wr_state_o(dir_wr_state_o),
        .dir_wr_owners_o(dir_wr_owners_o), .retire_valid_o(retire_valid_o),
        .retire_addr_o(retire_addr_o)
    );

    // Directory and probe model.
    logic [1:0]          m_st  [NUM_ADDR];
    logic [NUM_PROC-1:0] m_own [NUM_ADDR];
    logic                m_pm  [NUM_ADDR];

    assign dir_state_i  = m_st[look_addr_o];
    assign dir_owners_i = m_own[look_addr_o];
    assign probe_mem_i  = m_pm[look_addr_o];

    always @(posedge clk) begin
        if (rst_n && dir_wr_o) begin
            m_st[dir_wr_addr_o]  <= dir_wr_state_o;
            m_own[dir_wr_addr_o] <= dir_wr_owners_o;
        end
    end

    typedef struct {
        bit g;
        int dest;
        int cnt;
        int addr;
        int st;
        int own;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    int   n_unexp = 0;
    int   cyc = 0;
    int   last_inv_cyc = -10;

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    // Expected messages of one served request.
    task automatic expect_txn(input int addr, input int pid, input int owners);
        int tgt;
        int c;
        exp_t e;
        tgt = owners & ~(1 << pid);
        c = 0;
        for (int p = 0; p < NUM_PROC; p++) begin
            if (tgt[p]) begin
                e = '{g: 1'b0, dest: p, cnt: 0, addr: addr, st: 0, own: 0};
                exp_q.push_back(e);
                c++;
            end
        end
        e = '{g: 1'b1, dest: pid, cnt: c, addr: addr,
              st: (pid == HOME_ID) ? 3 : 2, own: 1 << pid};
        exp_q.push_back(e);
    endtask

    // Offers one request and holds it until accepted.
    task automatic send(input int a, input int p, input bit c);
        req_addr_i  = AW'(a);
        req_pid_i   = PW'(p);
        req_cmd_i   = c;
        req_valid_i = 1'b1;
        #1;
        while (!req_ready_o) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        req_valid_i = 1'b0;
    endtask

    task automatic wait_drain(input string what);
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 500) begin
            @(posedge clk); #1;
            n++;
        end
        repeat (3) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, what, exp_q.size(), 0);
    endtask

    // Monitor: compares every strobe with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (dir_wr_o && !grant_valid_o)
                chk(0, "R6 directory write without grant", 1, 0);
            if (inv_valid_o || grant_valid_o) begin
                if (exp_q.size() == 0) begin
                    n_unexp++;
                    chk(0, "R3 unexpected message", int'(grant_valid_o), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (!e.g) begin
                        chk(inv_valid_o && !grant_valid_o, "R4 invalidate expected",
                            int'(grant_valid_o), 0);
                        chk(int'(inv_dest_o) == e.dest, "R4 invalidate destination",
                            int'(inv_dest_o), e.dest);
                        last_inv_cyc = cyc;
                    end else begin
                        chk(grant_valid_o, "R5 grant expected", int'(grant_valid_o), 1);
                        chk(int'(grant_dest_o) == e.dest, "R5 grant destination",
                            int'(grant_dest_o), e.dest);
                        chk(int'(grant_count_o) == e.cnt, "R5 grant count",
                            int'(grant_count_o), e.cnt);
                        if (e.cnt > 0)
                            chk(last_inv_cyc == cyc - 1, "R5 grant after last invalidate",
                                last_inv_cyc, cyc - 1);
                        chk(dir_wr_o && int'(dir_wr_addr_o) == e.addr,
                            "R6 directory write address", int'(dir_wr_addr_o), e.addr);
                        chk(int'(dir_wr_state_o) == e.st,
                            (e.st == 3) ? "R7 stale state" : "R6 exclusive state",
                            int'(dir_wr_state_o), e.st);
                        chk(int'(dir_wr_owners_o) == e.own,
                            (e.st == 3) ? "R7 stale owners" : "R6 exclusive owner",
                            int'(dir_wr_owners_o), e.own);
                        chk(retire_valid_o && int'(retire_addr_o) == e.addr,
                            "R8 retire address", int'(retire_addr_o), e.addr);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int a = 0; a < NUM_ADDR; a++) begin
            m_st[a]  = 2'd0;
            m_own[a] = '0;
            m_pm[a]  = 1'b1;
        end
        repeat (3) @(posedge clk);
        #1;
        chk(!inv_valid_o && !grant_valid_o && !dir_wr_o && !retire_valid_o,
            "R1 strobes low in reset", int'(grant_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!inv_valid_o && !grant_valid_o && !dir_wr_o && !retire_valid_o,
            "R1 strobes low after reset", int'(inv_valid_o), 0);
        chk(req_ready_o, "R1 ready after reset", int'(req_ready_o), 1);
        @(posedge clk); #1;

        // R4 R6: three sharers, requester not among them.
        m_st[1] = 2'd1; m_own[1] = 8'b0010_1010;
        expect_txn(1, 2, 8'b0010_1010);
        send(1, 2, 1'b1);
        wait_drain("R4 three sharers drained");

        // R4 R5: requester is one of the sharers.
        m_st[2] = 2'd1; m_own[2] = 8'b0101_0100;
        expect_txn(2, 4, 8'b0101_0100);
        send(2, 4, 1'b1);
        wait_drain("R5 requester among sharers drained");

        // R7: home node takes the line.
        m_st[3] = 2'd1; m_own[3] = 8'b1000_0001;
        expect_txn(3, HOME_ID, 8'b1000_0001);
        send(3, HOME_ID, 1'b1);
        wait_drain("R7 home request drained");

        // R5: requester is the only sharer, zero count.
        m_st[0] = 2'd1; m_own[0] = 8'b0010_0000;
        expect_txn(0, 5, 8'b0010_0000);
        send(0, 5, 1'b1);
        wait_drain("R5 zero-target grant drained");

        // R3: three requests that each miss one precondition.
        m_st[0] = 2'd1; m_own[0] = 8'b0000_0110; m_pm[0] = 1'b0;
        send(0, 3, 1'b1);                 // probe says not in memory
        send(1, 3, 1'b1);                 // line is Exclusive
        send(3, 1, 1'b0);                 // read command
        repeat (40) @(posedge clk);
        #1;
        chk(n_unexp == 0, "R3 blocked heads send nothing", n_unexp, 0);

        // R3: releasing the probe lets line 0 proceed, others stay.
        expect_txn(0, 3, 8'b0000_0110);
        m_pm[0] = 1'b1;
        wait_drain("R3 released probe drained");
        chk(n_unexp == 0, "R3 other heads stay quiet", n_unexp, 0);

        // R2: the stalled head of line 1 runs once the line is Shared.
        expect_txn(1, 3, 8'b0100_0001);
        m_own[1] = 8'b0100_0001; m_st[1] = 2'd1;
        wait_drain("R2 stalled head served after release");

        // R2 R8: two requests on one line, the second sees the new entry.
        m_st[2] = 2'd1; m_own[2] = 8'b0001_0010;
        expect_txn(2, 1, 8'b0001_0010);
        send(2, 1, 1'b1);
        send(2, 7, 1'b1);
        wait_drain("R8 first of pair served");
        repeat (20) @(posedge clk);
        #1;
        chk(n_unexp == 0, "R8 second waits on Exclusive entry", n_unexp, 0);
        expect_txn(2, 7, 8'b0000_1010);
        m_own[2] = 8'b0000_1010; m_st[2] = 2'd1;
        wait_drain("R2 second of pair served in order");

        // R2: fill line 3 (one blocked read already queued).
        for (int i = 0; i < QDEPTH - 1; i++) send(3, 2, 1'b0);
        req_addr_i = AW'(3);
        #1;
        chk(!req_ready_o, "R2 ready low when queue full", int'(req_ready_o), 0);
        req_addr_i = AW'(0);
        #1;
        chk(req_ready_o, "R2 other queue still ready", int'(req_ready_o), 1);
        chk(n_unexp == 0, "R3 queued reads send nothing", n_unexp, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule